// File: doc/BRIEF.md
# Bridge memory window decoder

This block decides which downstream PCI Express port, if any, owns a memory request. Each port is seen by software as a virtual PCI-to-PCI bridge. Each port has two address windows. The first is a non-prefetchable window that always lies below 4 GB. The second is a prefetchable window whose base and limit are each built from a lower register and an upper register, which lets it sit above 4 GB. Physical addresses are 36 bits wide, so only the lowest 4 bits of each upper register take part in the decode. Window bounds have 1 MB granularity.

A request is a 36-bit address presented with a valid strobe. One clock later the block gives a one-hot port select, or a "not claimed" indication so that the request can go to main memory or elsewhere. A port claims nothing while its memory access enable bit is clear. When the first port runs in the wide (x8) link mode, the second port's windows collapse and that port never claims anything. If windows overlap illegally, the lowest-numbered port wins and an overlap flag is raised. A separate registered flag reports any non-empty window of a live port that is placed outside the regions the system allows.

Top module: `mem_window_decoder`

## Requirements
- R1: While reset is asserted, `selValid`, `portSel`, `notClaimed`, `overlapErr` and `progErr` are all zero, whatever the inputs are.
- R2: `selValid` is high exactly one cycle after a cycle with `reqValid` high. After a cycle without a request, `portSel`, `notClaimed` and `overlapErr` are zero.
- R3: The non-prefetchable window of port p claims every address whose bits 35:20 lie in `{4'h0, npBase[p]}` to `{4'h0, npLimit[p]}` inclusive. The low 20 bits of the base count as zeros and the low 20 bits of the limit count as ones.
- R4: The prefetchable window of port p runs from `{pfBaseHi[p][3:0], pfBaseLo[p]}` to `{pfLimitHi[p][3:0], pfLimitLo[p]}` in 1 MB units. Bits 31:4 of the upper registers have no effect.
- R5: A port whose `memEnable` bit is clear claims no address in either of its windows.
- R6: While `wideLinkMode` is high, port 1 claims no address, even when its registers hold valid ranges. Port 0 is not affected.
- R7: When `selValid` is high, `portSel` has at most one bit set, with bit p meaning port p. `notClaimed` is high exactly when no bit is set.
- R8: A window whose base is greater than its limit is empty. It claims no address and is never reported as misplaced.
- R9: When more than one window matches, the lowest-numbered port that has a match is selected and `overlapErr` is high in the same cycle as the select.
- R10: `progErr` goes high one cycle after a live port (enabled, and not removed by wide mode) has a non-empty non-prefetchable window whose base is below `tolm`.
- R11: `progErr` goes high one cycle after a live port has a non-empty prefetchable window that lies neither wholly within [`tolm`, 4 GB) nor at or above `tomm`. It stays low for legal placements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe for `reqAddr` |
| reqAddr | input | 36 | Request byte address |
| memEnable | input | 2 | Per-port memory access enable |
| wideLinkMode | input | 1 | First port in x8 mode; removes port 1 |
| tolm | input | 12 | Top of low memory, 1 MB units below 4 GB |
| tomm | input | 16 | Top of main memory, 1 MB units |
| npBase | input | 2x12 | Non-prefetchable base per port, address bits 31:20 |
| npLimit | input | 2x12 | Non-prefetchable limit per port, address bits 31:20 |
| pfBaseLo | input | 2x12 | Prefetchable base per port, address bits 31:20 |
| pfLimitLo | input | 2x12 | Prefetchable limit per port, address bits 31:20 |
| pfBaseHi | input | 2x32 | Prefetchable upper base register; bits 3:0 are address bits 35:32 |
| pfLimitHi | input | 2x32 | Prefetchable upper limit register; bits 3:0 are address bits 35:32 |
| selValid | output | 1 | Decode result valid |
| portSel | output | 2 | One-hot owning port |
| notClaimed | output | 1 | No window claimed the request |
| overlapErr | output | 1 | More than one window matched |
| progErr | output | 1 | A live window is placed in an illegal region |

## Verification
On every cycle the assertions check the one-cycle strobe relation and the idle state of the outputs. They also check that the select is one-hot or marked unclaimed, that a disabled port or the collapsed second port is never chosen, and that the overlap flag only comes with a single chosen port. What cannot be shown in a single cycle is whether a given address lands in the right window. That covers the inclusive 1 MB edges, the joined upper nibble with junk in the high register bits, empty windows, priority on overlap and the placement rules against `tolm` and `tomm`. These are shown by the bench's vector table and its directed scenarios.

// File: rtl/mwd_pkg.sv
package mwd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the decode of the current address
    logic flush;    // clear the result registers
  } mwd_strobe_t;

endpackage

// File: rtl/mwd_window_match.sv
module mwd_window_match #(
  parameter int MB_W = 16
) (
  input  logic            enable,
  input  logic [MB_W-1:0] addrMb,
  input  logic [MB_W-1:0] baseMb,
  input  logic [MB_W-1:0] limitMb,
  output logic            hit,
  output logic            isEmpty
);

  logic aboveBase;
  logic belowLimit;

  assign isEmpty    = baseMb > limitMb;
  assign aboveBase  = addrMb >= baseMb;
  assign belowLimit = addrMb <= limitMb;
  assign hit        = enable && !isEmpty && aboveBase && belowLimit;

endmodule

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output mwd_strobe_t strobe,
  output logic        selValid
);

  always_comb begin
    strobe.capture = reqValid;
    strobe.flush   = !reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) selValid <= 1'b0;
    else       selValid <= reqValid;
  end

endmodule

// File: rtl/mwd_datapath.sv
module mwd_datapath
  import mwd_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int GRAN_W    = 20,
  parameter int NUM_PORTS = 2,
  parameter int HI_REG_W  = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  mwd_strobe_t                           strobe,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [NUM_PORTS-1:0]                  memEnable,
  input  logic                                  wideLinkMode,
  input  logic [31-GRAN_W:0]                    tolm,
  input  logic [ADDR_W-GRAN_W-1:0]              tomm,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     npBase,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     npLimit,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     pfBaseLo,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     pfLimitLo,
  input  logic [NUM_PORTS-1:0][HI_REG_W-1:0]    pfBaseHi,
  input  logic [NUM_PORTS-1:0][HI_REG_W-1:0]    pfLimitHi,
  output logic [NUM_PORTS-1:0]                  portSel,
  output logic                                  notClaimed,
  output logic                                  overlapErr,
  output logic                                  progErr
);

  localparam int MB_W  = ADDR_W - GRAN_W;   // address bits compared
  localparam int LO_W  = 32 - GRAN_W;       // bits below 4 GB
  localparam int HI_W  = ADDR_W - 32;       // implemented upper bits
  localparam int NWIN  = 2 * NUM_PORTS;
  localparam int CNT_W = $clog2(NWIN + 1);

  logic [MB_W-1:0]      addrMb;
  logic [MB_W-1:0]      tolmMb;
  logic [NUM_PORTS-1:0] portLive;
  logic [NUM_PORTS-1:0] npHit;
  logic [NUM_PORTS-1:0] pfHit;
  logic [NUM_PORTS-1:0] portBad;

  assign addrMb = reqAddr[ADDR_W-1:GRAN_W];
  assign tolmMb = {{HI_W{1'b0}}, tolm};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [MB_W-1:0] npBaseMb, npLimitMb, pfBaseMb, pfLimitMb;
    logic            npEmpty, pfEmpty;
    logic            npLegal, pfLegal, pfLowOk, pfHighOk;

    // second port disappears in wide-link mode
    if (p == 1) begin : g_collapse
      assign portLive[p] = memEnable[p] && !wideLinkMode;
    end else begin : g_plain
      assign portLive[p] = memEnable[p];
    end

    assign npBaseMb  = {{HI_W{1'b0}}, npBase[p]};
    assign npLimitMb = {{HI_W{1'b0}}, npLimit[p]};
    assign pfBaseMb  = {pfBaseHi[p][HI_W-1:0],  pfBaseLo[p]};
    assign pfLimitMb = {pfLimitHi[p][HI_W-1:0], pfLimitLo[p]};

    mwd_window_match #(.MB_W(MB_W)) u_np (
      .enable (portLive[p]),
      .addrMb (addrMb),
      .baseMb (npBaseMb),
      .limitMb(npLimitMb),
      .hit    (npHit[p]),
      .isEmpty(npEmpty)
    );

    mwd_window_match #(.MB_W(MB_W)) u_pf (
      .enable (portLive[p]),
      .addrMb (addrMb),
      .baseMb (pfBaseMb),
      .limitMb(pfLimitMb),
      .hit    (pfHit[p]),
      .isEmpty(pfEmpty)
    );

    // placement rules; limits below 4 GB hold by register width
    assign npLegal  = npEmpty || (npBaseMb >= tolmMb);
    assign pfLowOk  = (pfBaseMb >= tolmMb) && (pfLimitMb[MB_W-1:LO_W] == '0);
    assign pfHighOk = pfBaseMb >= tomm;
    assign pfLegal  = pfEmpty || pfLowOk || pfHighOk;
    assign portBad[p] = portLive[p] && !(npLegal && pfLegal);
  end

  logic [NUM_PORTS-1:0] selNext;
  logic [CNT_W-1:0]     hitCount;

  always_comb begin
    logic found;
    found    = 1'b0;
    selNext  = '0;
    hitCount = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      hitCount = hitCount + CNT_W'(npHit[p]) + CNT_W'(pfHit[p]);
      if (!found && (npHit[p] || pfHit[p])) begin
        selNext[p] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portSel    <= '0;
      notClaimed <= 1'b0;
      overlapErr <= 1'b0;
    end else if (strobe.capture) begin
      portSel    <= selNext;
      notClaimed <= (selNext == '0);
      overlapErr <= hitCount > CNT_W'(1);
    end else if (strobe.flush) begin
      portSel    <= '0;
      notClaimed <= 1'b0;
      overlapErr <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) progErr <= 1'b0;
    else       progErr <= |portBad;
  end

endmodule

// File: rtl/mem_window_decoder.sv
module mem_window_decoder
  import mwd_pkg::*;
#(
  parameter int ADDR_W    = 36,
  parameter int GRAN_W    = 20,
  parameter int NUM_PORTS = 2,
  parameter int HI_REG_W  = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  reqValid,
  input  logic [ADDR_W-1:0]                     reqAddr,
  input  logic [NUM_PORTS-1:0]                  memEnable,
  input  logic                                  wideLinkMode,
  input  logic [31-GRAN_W:0]                    tolm,
  input  logic [ADDR_W-GRAN_W-1:0]              tomm,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     npBase,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     npLimit,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     pfBaseLo,
  input  logic [NUM_PORTS-1:0][31-GRAN_W:0]     pfLimitLo,
  input  logic [NUM_PORTS-1:0][HI_REG_W-1:0]    pfBaseHi,
  input  logic [NUM_PORTS-1:0][HI_REG_W-1:0]    pfLimitHi,
  output logic                                  selValid,
  output logic [NUM_PORTS-1:0]                  portSel,
  output logic                                  notClaimed,
  output logic                                  overlapErr,
  output logic                                  progErr
);

  mwd_strobe_t strobe;

  mwd_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .strobe  (strobe),
    .selValid(selValid)
  );

  mwd_datapath #(
    .ADDR_W   (ADDR_W),
    .GRAN_W   (GRAN_W),
    .NUM_PORTS(NUM_PORTS),
    .HI_REG_W (HI_REG_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .memEnable   (memEnable),
    .wideLinkMode(wideLinkMode),
    .tolm        (tolm),
    .tomm        (tomm),
    .npBase      (npBase),
    .npLimit     (npLimit),
    .pfBaseLo    (pfBaseLo),
    .pfLimitLo   (pfLimitLo),
    .pfBaseHi    (pfBaseHi),
    .pfLimitHi   (pfLimitHi),
    .portSel     (portSel),
    .notClaimed  (notClaimed),
    .overlapErr  (overlapErr),
    .progErr     (progErr)
  );

endmodule

// File: rtl/mwd_checker.sv
module mwd_checker #(
  parameter int NUM_PORTS = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [NUM_PORTS-1:0] memEnable,
  input logic                 wideLinkMode,
  input logic                 selValid,
  input logic [NUM_PORTS-1:0] portSel,
  input logic                 notClaimed,
  input logic                 overlapErr,
  input logic                 progErr
);

  // R1: outputs held at zero through reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!selValid && portSel == '0 && !notClaimed && !overlapErr && !progErr));

  // R2: result follows the strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> selValid);

  // R2: idle cycle leaves the result lines at zero
  a_r2_idle_clear: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!selValid && portSel == '0 && !notClaimed && !overlapErr));

  // R7: select is one-hot or the request is unclaimed
  a_r7_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> ($onehot0(portSel) && (notClaimed == (portSel == '0))));

  // R5: disabled port is never chosen
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
    a_r5_disabled_port: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && !memEnable[p]) |=> !portSel[p]);
  end

  // R6: collapsed second port is never chosen
  if (NUM_PORTS > 1) begin : g_wide
    a_r6_wide_collapse: assert property (@(posedge clk) disable iff (!rstN)
      (reqValid && wideLinkMode) |=> !portSel[1]);
  end

  // R9: overlap only reported alongside a single winner
  a_r9_overlap_winner: assert property (@(posedge clk) disable iff (!rstN)
    overlapErr |-> (selValid && !notClaimed && $countones(portSel) == 1));

endmodule

bind mem_window_decoder mwd_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .memEnable   (memEnable),
  .wideLinkMode(wideLinkMode),
  .selValid    (selValid),
  .portSel     (portSel),
  .notClaimed  (notClaimed),
  .overlapErr  (overlapErr),
  .progErr     (progErr)
);

// File: tb/mem_window_decoder_tb.sv
module mem_window_decoder_tb;

  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rstN;
  logic             reqValid;
  logic [35:0]      reqAddr;
  logic [1:0]       memEnable;
  logic             wideLinkMode;
  logic [11:0]      tolm;
  logic [15:0]      tomm;
  logic [1:0][11:0] npBase, npLimit, pfBaseLo, pfLimitLo;
  logic [1:0][31:0] pfBaseHi, pfLimitHi;
  logic             selValid;
  logic [1:0]       portSel;
  logic             notClaimed, overlapErr, progErr;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_window_decoder u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .memEnable(memEnable), .wideLinkMode(wideLinkMode), .tolm(tolm), .tomm(tomm),
    .npBase(npBase), .npLimit(npLimit), .pfBaseLo(pfBaseLo), .pfLimitLo(pfLimitLo),
    .pfBaseHi(pfBaseHi), .pfLimitHi(pfLimitHi), .selValid(selValid), .portSel(portSel),
    .notClaimed(notClaimed), .overlapErr(overlapErr), .progErr(progErr)
  );

  typedef struct packed {
    logic [35:0] addr;
    logic [1:0]  en;
    logic        wide;
    logic [1:0]  expSel;
    logic        expNc;
    logic [7:0]  req;
  } vec_t;

  // Config: P0 np C00-C0F, pf 1000-10FF; P1 np D00-D0F, pf 2000-20FF (MB)
  localparam vec_t VECS [15] = '{
    '{36'h0_C000_0000, 2'b11, 1'b0, 2'b01, 1'b0, 8'd3},  // R3 base edge
    '{36'h0_C0FF_FFFF, 2'b11, 1'b0, 2'b01, 1'b0, 8'd3},  // R3 limit edge
    '{36'h0_C100_0000, 2'b11, 1'b0, 2'b00, 1'b1, 8'd3},  // R3 just above
    '{36'h0_BFFF_FFFF, 2'b11, 1'b0, 2'b00, 1'b1, 8'd3},  // R3 just below
    '{36'h1_0000_0000, 2'b11, 1'b0, 2'b01, 1'b0, 8'd4},  // R4 pf base
    '{36'h1_0FFF_FFFF, 2'b11, 1'b0, 2'b01, 1'b0, 8'd4},  // R4 pf limit
    '{36'h1_1000_0000, 2'b11, 1'b0, 2'b00, 1'b1, 8'd4},  // R4 above
    '{36'h0_D050_0000, 2'b11, 1'b0, 2'b10, 1'b0, 8'd7},  // R7 port1 np
    '{36'h2_0080_0000, 2'b11, 1'b0, 2'b10, 1'b0, 8'd7},  // R7 port1 pf
    '{36'h0_D050_0000, 2'b01, 1'b0, 2'b00, 1'b1, 8'd5},  // R5 port1 off
    '{36'h0_C000_0000, 2'b10, 1'b0, 2'b00, 1'b1, 8'd5},  // R5 port0 off
    '{36'h0_D050_0000, 2'b11, 1'b1, 2'b00, 1'b1, 8'd6},  // R6 np gone
    '{36'h2_0000_0000, 2'b11, 1'b1, 2'b00, 1'b1, 8'd6},  // R6 pf gone
    '{36'h0_C050_0000, 2'b11, 1'b1, 2'b01, 1'b0, 8'd6},  // R6 port0 kept
    '{36'h3_0000_0000, 2'b11, 1'b0, 2'b00, 1'b1, 8'd4}   // R4 junk upper bits
  };

  task automatic check(input bit ok, input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic setConfig();
    tolm = 12'hC00; tomm = 16'h1000;
    npBase[0] = 12'hC00; npLimit[0] = 12'hC0F;
    pfBaseLo[0] = 12'h000; pfLimitLo[0] = 12'h0FF;
    pfBaseHi[0] = 32'hABCD_EF01; pfLimitHi[0] = 32'h1234_5671;
    npBase[1] = 12'hD00; npLimit[1] = 12'hD0F;
    pfBaseLo[1] = 12'h000; pfLimitLo[1] = 12'h0FF;
    pfBaseHi[1] = 32'h0000_0002; pfLimitHi[1] = 32'hFFFF_FFF2;
  endtask

  task automatic doReq(input logic [35:0] a, input logic [1:0] en, input logic w);
    reqAddr = a; memEnable = en; wideLinkMode = w; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectSel(input int req, input string what,
                           input logic [1:0] s, input logic nc, input logic ov);
    check(selValid == 1'b1, 2, {what, " selValid"}, selValid, 1);
    check(portSel == s, req, {what, " portSel"}, portSel, s);
    check(notClaimed == nc, req, {what, " notClaimed"}, notClaimed, nc);
    check(overlapErr == ov, 9, {what, " overlapErr"}, overlapErr, ov);
  endtask

  task automatic expectProg(input int req, input string what, input logic e);
    @(negedge clk);
    check(progErr == e, req, what, progErr, e);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b1; reqAddr = 36'h0_C000_0000;
    memEnable = 2'b11; wideLinkMode = 1'b0;
    setConfig();
    npBase[0] = 12'h100;  // illegal, must stay hidden in reset
    repeat (3) @(negedge clk);
    // R1 reset state
    check(selValid == 0 && portSel == 0 && !notClaimed && !overlapErr && !progErr, 1,
          "reset outputs", {selValid, portSel, notClaimed, overlapErr, progErr}, 0);
    reqValid = 1'b0; setConfig();
    rstN = 1'b1;
    @(negedge clk);
    check(progErr == 0, 11, "legal config", progErr, 0);

    foreach (VECS[i]) begin
      doReq(VECS[i].addr, VECS[i].en, VECS[i].wide);
      expectSel(int'(VECS[i].req), $sformatf("vec%0d", i), VECS[i].expSel, VECS[i].expNc, 1'b0);
    end

    // R2 idle cycle after a request
    @(negedge clk);
    check(selValid == 0 && portSel == 0 && !notClaimed, 2, "idle clears",
          {selValid, portSel, notClaimed}, 0);

    // R8 empty window below tolm: claims nothing, not flagged
    npBase[0] = 12'hA00; npLimit[0] = 12'h900;
    doReq(36'h0_9500_0000, 2'b11, 1'b0);
    expectSel(8, "empty window", 2'b00, 1'b1, 1'b0);
    check(progErr == 0, 8, "empty not flagged", progErr, 0);
    setConfig();

    // R9 overlap: port1 np covers C08-C0F
    npBase[1] = 12'hC08; npLimit[1] = 12'hC0F;
    doReq(36'h0_C0A0_0000, 2'b11, 1'b0);
    expectSel(9, "overlap", 2'b01, 1'b0, 1'b1);
    doReq(36'h0_C020_0000, 2'b11, 1'b0);
    expectSel(9, "no overlap", 2'b01, 1'b0, 1'b0);
    setConfig();

    // R10 np base below tolm
    npBase[0] = 12'hB00;
    expectProg(10, "np below tolm", 1'b1);
    setConfig();
    expectProg(10, "np restored", 1'b0);

    // R11 pf placements
    pfBaseLo[1] = 12'hE00; pfLimitLo[1] = 12'hEFF; pfBaseHi[1] = 0; pfLimitHi[1] = 0;
    expectProg(11, "pf in low hole", 1'b0);
    pfBaseLo[1] = 12'hF00; pfLimitLo[1] = 12'h0FF; pfLimitHi[1] = 32'h1;
    expectProg(11, "pf straddles 4GB", 1'b1);
    wideLinkMode = 1'b1;
    expectProg(6, "collapsed port not checked", 1'b0);
    wideLinkMode = 1'b0; setConfig();
    pfBaseLo[0] = 12'h800; pfBaseHi[0] = 0; pfLimitLo[0] = 12'h8FF; pfLimitHi[0] = 0;
    expectProg(11, "pf below tolm", 1'b1);
    memEnable = 2'b10;
    expectProg(5, "disabled port not checked", 1'b0);
    memEnable = 2'b11; setConfig();
    expectProg(11, "pf restored", 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule